// File: doc/BRIEF.md
# Chained Word DMA Channel

This block moves 36-bit words between a device and main memory, steered by a chain of control words held in memory. Software places a list of control words in memory, then gives the channel the list's address and a direction. The channel keeps four pieces of state: a word count, a current data address, a control-word pointer and status flags. It walks the list by itself. Each control word is either a data descriptor, a jump to another part of the list, or the end of the list.

A data descriptor carries a count in its upper 18 bits and an address in its lower 18 bits. The count is the number of words to move, written as a negative number that counts up toward zero. The address points one word below the first word moved. A descriptor whose address is zero is a skip transfer: the device stream still advances, but memory is never touched. When the list ends, or when an access falls outside installed memory, the channel writes a status word back into the list, raises its completion flag and holds its interrupt request until software clears it.

Device data moves on valid/ready streams. Toward the device, `dout_valid` stays high with `dout_data` unchanged until `dout_ready` is seen high at a clock edge. From the device, a word is taken at an edge where both `din_valid` and `din_ready` are high. A device may therefore stall either stream for any number of cycles. The memory port follows the same rule: the request holds its address, direction and write data until `mem_gnt` is high. Read data on `mem_rdata` is taken in the grant cycle.

Top module: `dch_chan`

## Requirements
- R1: After reset the channel is idle. `busy`, `irq`, `stat_done`, `stat_nxm`, `mem_req`, `dout_valid` and `din_ready` are all low.
- R2: A start pulse while idle clears the status and sets the count to zero. The channel then reads its first control word from `start_cwp`. A control word decodes as count = bits [35:18] and address = bits [17:0]. A nonzero count makes it a data descriptor: the count and address are loaded, and the pointer moves on by one.
- R3: With `start_dir` = 0 (memory to device), each step first increments the address and then reads memory at the new address. The word read is offered on `dout_data` and held stable while `dout_ready` is low.
- R4: With `start_dir` = 1 (device to memory), each word accepted on the input stream is stored at the incremented address. A descriptor with address A therefore fills A+1, A+2, and so on.
- R5: Every step increments the count, modulo 2^18. When the count reaches zero, the next control word is fetched at once, without waiting for the device.
- R6: A descriptor with address zero is a skip transfer. A read step delivers a zero word. A write step discards the word. Neither step makes a memory access or advances the address.
- R7: A control word with count zero and a nonzero address is a jump. The next control word is read from that address.
- R8: A control word with count zero and address zero ends the chain. The channel writes {count, address} (count in bits [35:18]) to the current pointer with bit 0 forced to 1. It then sets `stat_done` and drops `busy`.
- R9: If an incremented address is not below `mem_limit`, no data access takes place. The count has already been incremented. The status word is written back as in R8, and both `stat_nxm` and `stat_done` are set.
- R10: `irq` follows `stat_done` and stays high until a `clr_status` pulse, which clears both status flags.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R12: `din_ready` and `dout_valid` are never high together, and neither is high while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_dir | input | 1 | 0: memory to device, 1: device to memory |
| start_cwp | input | 18 | Address of the first control word |
| mem_limit | input | 19 | Installed memory size in words |
| clr_status | input | 1 | Pulse that clears the status flags and the interrupt |
| busy | output | 1 | Channel active |
| stat_done | output | 1 | Completion flag |
| stat_nxm | output | 1 | Non-existent-memory flag |
| irq | output | 1 | Level interrupt request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 36 | Memory write data |
| mem_gnt | input | 1 | Memory grant (ready) |
| mem_rdata | input | 36 | Memory read data, valid in the grant cycle |
| dout_valid | output | 1 | Word toward the device is valid |
| dout_ready | input | 1 | Device accepts the word |
| dout_data | output | 36 | Word toward the device |
| din_valid | input | 1 | Device offers a word |
| din_ready | output | 1 | Channel accepts the offered word |
| din_data | input | 36 | Word from the device |

## Verification
The assertions check the handshake rules on every cycle. The memory request must hold while not granted, and the outgoing word must hold while not accepted. The two device streams must never be active together, and the idle channel must stay silent. The interrupt must hold until it is cleared. The first action after a start must be a control-word read, and any rise of the interrupt must follow a granted write. Only the directed scenarios can show the rest: the data addresses and values moved, the skip and jump decoding, the immediate fetch after a count runs out, and the exact status word and where it lands. The bench memory model delays grants at random, so those scenarios also run under memory back-pressure.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FETCH,
    ST_MEM,
    ST_OUT,
    ST_WB
  } dch_state_e;

  typedef enum logic [1:0] {
    CW_DATA,
    CW_JUMP,
    CW_HALT
  } cw_kind_e;
endpackage

// File: rtl/dch_cw_decode.sv
module dch_cw_decode
  import dch_pkg::*;
#(
  parameter int CNT_W  = 18,
  parameter int ADDR_W = 18,
  localparam int WORD_W = CNT_W + ADDR_W
) (
  input  logic [WORD_W-1:0] word,
  output cw_kind_e          kind,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr
);
  assign cnt  = word[WORD_W-1:ADDR_W];
  assign addr = word[ADDR_W-1:0];

  always_comb begin
    if (cnt != '0)       kind = CW_DATA;
    else if (addr != '0) kind = CW_JUMP;
    else                 kind = CW_HALT;
  end
endmodule

// File: rtl/dch_step_calc.sv
module dch_step_calc #(
  parameter int CNT_W  = 18,
  parameter int ADDR_W = 18
) (
  input  logic [CNT_W-1:0]  wc,
  input  logic [ADDR_W-1:0] cda,
  input  logic [ADDR_W:0]   limit,
  output logic [CNT_W-1:0]  wc_nx,
  output logic [ADDR_W-1:0] cda_nx,
  output logic              skip,
  output logic              nxm
);
  assign wc_nx  = wc + CNT_W'(1);
  assign cda_nx = cda + ADDR_W'(1);
  assign skip   = (cda == '0);
  // the check applies to the address about to be touched
  assign nxm    = !skip && ({1'b0, cda_nx} >= limit);
endmodule

// File: rtl/dch_wb_pack.sv
module dch_wb_pack #(
  parameter int CNT_W     = 18,
  parameter int ADDR_W    = 18,
  parameter bit FORCE_ODD = 1'b1,
  localparam int WORD_W = CNT_W + ADDR_W
) (
  input  logic [CNT_W-1:0]  wc,
  input  logic [ADDR_W-1:0] cda,
  input  logic [ADDR_W-1:0] cwp,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [WORD_W-1:0] wb_word
);
  assign wb_word = {wc, cda};

  generate
    if (FORCE_ODD) begin : g_odd
      assign wb_addr = cwp | ADDR_W'(1);
    end else begin : g_plain
      assign wb_addr = cwp;
    end
  endgenerate
endmodule

// File: rtl/dch_chan.sv
module dch_chan
  import dch_pkg::*;
#(
  parameter int CNT_W  = 18,
  parameter int ADDR_W = 18,
  localparam int WORD_W = CNT_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic [ADDR_W-1:0] start_cwp,
  input  logic [ADDR_W:0]   mem_limit,
  input  logic              clr_status,
  output logic              busy,
  output logic              stat_done,
  output logic              stat_nxm,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [WORD_W-1:0] dout_data,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [WORD_W-1:0] din_data
);
  dch_state_e        state;
  logic              dir_wr;
  logic              err_pend;
  logic [CNT_W-1:0]  wc;
  logic [ADDR_W-1:0] cda;
  logic [ADDR_W-1:0] cwp;
  logic [WORD_W-1:0] data_q;

  cw_kind_e          cw_kind;
  logic [CNT_W-1:0]  cw_cnt;
  logic [ADDR_W-1:0] cw_addr;
  logic [CNT_W-1:0]  wc_nx;
  logic [ADDR_W-1:0] cda_nx;
  logic              step_skip;
  logic              step_nxm;
  logic [ADDR_W-1:0] wb_addr;
  logic [WORD_W-1:0] wb_word;

  dch_cw_decode #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dec (
    .word (mem_rdata),
    .kind (cw_kind),
    .cnt  (cw_cnt),
    .addr (cw_addr)
  );

  dch_step_calc #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_step (
    .wc     (wc),
    .cda    (cda),
    .limit  (mem_limit),
    .wc_nx  (wc_nx),
    .cda_nx (cda_nx),
    .skip   (step_skip),
    .nxm    (step_nxm)
  );

  dch_wb_pack #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .FORCE_ODD(1'b1)) u_wb (
    .wc      (wc),
    .cda     (cda),
    .cwp     (cwp),
    .wb_addr (wb_addr),
    .wb_word (wb_word)
  );

  // output decode
  assign busy       = (state != ST_IDLE);
  assign irq        = stat_done;
  assign dout_valid = (state == ST_OUT);
  assign dout_data  = data_q;
  assign din_ready  = (state == ST_RUN) && dir_wr && (wc != '0);
  assign mem_req    = (state == ST_FETCH) || (state == ST_MEM) || (state == ST_WB);
  assign mem_we     = ((state == ST_MEM) && dir_wr) || (state == ST_WB);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_FETCH: mem_addr = cwp;
      ST_MEM: begin
        mem_addr  = cda;
        mem_wdata = data_q;
      end
      ST_WB: begin
        mem_addr  = wb_addr;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir_wr    <= 1'b0;
      err_pend  <= 1'b0;
      wc        <= '0;
      cda       <= '0;
      cwp       <= '0;
      data_q    <= '0;
      stat_done <= 1'b0;
      stat_nxm  <= 1'b0;
    end else begin
      if (clr_status) begin
        stat_done <= 1'b0;
        stat_nxm  <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            dir_wr    <= start_dir;
            cwp       <= start_cwp;
            wc        <= '0;
            cda       <= '0;
            err_pend  <= 1'b0;
            stat_done <= 1'b0;
            stat_nxm  <= 1'b0;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (wc == '0) begin
            state <= ST_FETCH;
          end else if (!dir_wr) begin
            wc <= wc_nx;
            if (step_skip) begin
              data_q <= '0;
              state  <= ST_OUT;
            end else if (step_nxm) begin
              err_pend <= 1'b1;
              state    <= ST_WB;
            end else begin
              cda   <= cda_nx;
              state <= ST_MEM;
            end
          end else if (din_valid) begin
            wc <= wc_nx;
            if (step_skip) begin
              state <= ST_RUN;
            end else if (step_nxm) begin
              err_pend <= 1'b1;
              state    <= ST_WB;
            end else begin
              cda    <= cda_nx;
              data_q <= din_data;
              state  <= ST_MEM;
            end
          end
        end
        ST_MEM: begin
          if (mem_gnt) begin
            if (!dir_wr) begin
              data_q <= mem_rdata;
              state  <= ST_OUT;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_OUT: begin
          if (dout_ready) state <= ST_RUN;
        end
        ST_FETCH: begin
          if (mem_gnt) begin
            case (cw_kind)
              CW_HALT: state <= ST_WB;
              CW_JUMP: cwp <= cw_addr;
              default: begin
                wc    <= cw_cnt;
                cda   <= cw_addr;
                cwp   <= cwp + ADDR_W'(1);
                state <= ST_RUN;
              end
            endcase
          end
        end
        ST_WB: begin
          if (mem_gnt) begin
            stat_done <= 1'b1;
            stat_nxm  <= err_pend;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dch_chan_chk.sv
module dch_chan_chk #(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq,
  input logic              stat_nxm,
  input logic              clr_status,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              dout_valid,
  input logic              dout_ready,
  input logic [WORD_W-1:0] dout_data,
  input logic              din_ready
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data));

  p_one_dir_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(din_ready && dout_valid));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dout_valid && !din_ready);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_status |=> irq);

  p_first_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> mem_req && !mem_we);

  p_irq_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_req && mem_we && mem_gnt) && !busy);

  p_nxm_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_nxm |-> irq);
endmodule

bind dch_chan dch_chan_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .irq        (irq),
  .stat_nxm   (stat_nxm),
  .clr_status (clr_status),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .dout_data  (dout_data),
  .din_ready  (din_ready)
);

// File: tb/dch_chan_tb.sv
module dch_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] SENT = 36'h5A5A5A5A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_dir = 1'b0;
  logic [17:0] start_cwp = '0;
  logic [18:0] mem_limit = 19'd1024;
  logic        clr_status = 1'b0;
  logic        busy, stat_done, stat_nxm, irq;
  logic        mem_req, mem_we, mem_gnt;
  logic [17:0] mem_addr;
  logic [35:0] mem_wdata, mem_rdata;
  logic        dout_valid;
  logic        dout_ready = 1'b0;
  logic [35:0] dout_data;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [35:0] din_data = '0;

  logic [35:0] mem [0:1023];
  logic [7:0]  lfsr = 8'h5B;
  int          rd_cnt = 0;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  logic [35:0] got [0:7];
  int          got_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dch_chan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .start_cwp(start_cwp), .mem_limit(mem_limit), .clr_status(clr_status),
    .busy(busy), .stat_done(stat_done), .stat_nxm(stat_nxm), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data)
  );

  // memory model with irregular grants
  assign mem_gnt   = mem_req && (lfsr[0] || lfsr[3]);
  assign mem_rdata = mem[mem_addr[9:0]];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        rd_cnt <= rd_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [35:0] cw(input logic [17:0] c, input logic [17:0] a);
    return {c, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_ch(input logic dir, input logic [17:0] p);
    @(negedge clk);
    start = 1'b1; start_dir = dir; start_cwp = p;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic collect(input int n);
    got_n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      dout_ready = lfsr[1];
      #1;
      if (dout_valid && dout_ready && got_n < 8) begin
        got[got_n] = dout_data;
        got_n = got_n + 1;
      end
      if (got_n == n || !busy) break;
    end
    @(negedge clk);
    dout_ready = 1'b0;
  endtask

  task automatic send(input logic [35:0] d);
    @(negedge clk);
    din_valid = 1'b1; din_data = d;
    for (int i = 0; i < 3000; i++) begin
      #1;
      if (din_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    din_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy, "R1 busy", {35'b0, busy}, 36'd0);
    chk(!irq && !stat_done && !stat_nxm, "R1 status", {33'b0, irq, stat_done, stat_nxm}, 36'd0);
    chk(!mem_req, "R1 mem_req", {35'b0, mem_req}, 36'd0);
    chk(!dout_valid && !din_ready, "R12 idle streams", {34'b0, dout_valid, din_ready}, 36'd0);
  endtask

  task automatic t_read_chain();
    mem[100] = cw(18'h3FFFD, 18'd199);
    mem[101] = cw(18'd0, 18'd0);
    for (int i = 0; i < 3; i++) mem[200+i] = 36'h100000000 + 36'(i * 7 + 3);
    start_ch(1'b0, 18'd100);
    collect(3);
    chk(got_n == 3, "R3 word count", 36'(got_n), 36'd3);
    for (int i = 0; i < 3; i++)
      chk(got[i] == mem[200+i], "R3 read data pre-incremented", got[i], mem[200+i]);
    wait_idle();
    chk(!busy, "R8 busy drops", {35'b0, busy}, 36'd0);
    chk(mem[101] == cw(18'd0, 18'd202), "R8 writeback word", mem[101], cw(18'd0, 18'd202));
    chk(stat_done && irq && !stat_nxm, "R8 done flags", {33'b0, stat_done, irq, stat_nxm}, 36'd6);
  endtask

  task automatic t_clear();
    repeat (3) @(negedge clk);
    chk(irq, "R10 irq held", {35'b0, irq}, 36'd1);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    chk(!irq && !stat_done, "R10 cleared", {34'b0, irq, stat_done}, 36'd0);
  endtask

  task automatic t_write_chain();
    mem[0] = SENT; mem[1] = SENT;
    mem[300] = cw(18'h3FFFE, 18'd399);
    mem[301] = cw(18'd0, 18'd310);
    mem[310] = cw(18'h3FFFE, 18'd0);
    mem[311] = cw(18'h3FFFF, 18'd499);
    mem[312] = cw(18'd0, 18'd0);
    mem[313] = SENT;
    rd_cnt = 0;
    start_ch(1'b1, 18'd300);
    send(36'h0AAAA0001);
    send(36'h0AAAA0002);
    repeat (40) @(negedge clk);
    // count hit zero: fetches of 300, 301 (jump) and 310 happen with no device word
    chk(rd_cnt == 3, "R5 immediate fetch / R7 jump", 36'(rd_cnt), 36'd3);
    send(36'h0BBBB0003);
    send(36'h0BBBB0004);
    send(36'h0CCCC0005);
    wait_idle();
    chk(mem[400] == 36'h0AAAA0001, "R4 first store", mem[400], 36'h0AAAA0001);
    chk(mem[401] == 36'h0AAAA0002, "R4 second store", mem[401], 36'h0AAAA0002);
    chk(mem[500] == 36'h0CCCC0005, "R7 store after jump", mem[500], 36'h0CCCC0005);
    chk(mem[0] == SENT && mem[1] == SENT, "R6 write skip discarded", mem[1], SENT);
    chk(mem[313] == cw(18'd0, 18'd500), "R8 writeback odd slot", mem[313], cw(18'd0, 18'd500));
    chk(stat_done && !stat_nxm, "R8 done", {34'b0, stat_done, stat_nxm}, 36'd2);
    clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic t_read_skip();
    mem[331] = cw(18'h3FFFE, 18'd0);
    mem[332] = cw(18'd0, 18'd0);
    mem[333] = SENT;
    rd_cnt = 0;
    start_ch(1'b0, 18'd331);
    collect(2);
    chk(got_n == 2 && got[0] == '0 && got[1] == '0, "R6 zero words", got[1], 36'd0);
    wait_idle();
    chk(rd_cnt == 2, "R6 no data reads", 36'(rd_cnt), 36'd2);
    chk(mem[333] == 36'd0, "R8 writeback forced odd", mem[333], 36'd0);
    clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic t_nxm();
    mem_limit = 19'd600;
    mem[340] = cw(18'h3FFFD, 18'd598);
    mem[341] = SENT;
    mem[599] = 36'h777000777;
    start_ch(1'b0, 18'd340);
    collect(3);
    chk(got_n == 1 && got[0] == 36'h777000777, "R9 only in-range word", 36'(got_n), 36'd1);
    wait_idle();
    chk(mem[341] == cw(18'h3FFFF, 18'd599), "R9 writeback", mem[341], cw(18'h3FFFF, 18'd599));
    chk(stat_nxm && stat_done && irq, "R9 flags", {33'b0, stat_nxm, stat_done, irq}, 36'd7);
    clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
    chk(!stat_nxm && !irq, "R10 nxm cleared", {34'b0, stat_nxm, irq}, 36'd0);
    mem_limit = 19'd1024;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = SENT;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read_chain();
    t_clear();
    t_write_chain();
    t_read_skip();
    t_nxm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule